// File: doc/BRIEF.md
# Impulse Noise Blanker Controller

The block removes short ignition-type spikes from a sampled stereo multiplex audio stream. One sample arrives on every clock. Each sample comes as a pair: an unsigned magnitude from an upstream high-band rectifier and the matching audio word. The block keeps a smoothed estimate of the rectified level and builds an adaptive trigger level from it. When a spike rises above that level, the audio output stays at the last good sample for a programmable number of sample periods.

The trigger level has three parts. The first is a programmable floor. The second is a term that grows with the noise estimate once that estimate is above a quiet-signal level. The third is an optional offset for over-deviated stations, added to the estimate itself. The hold timer is retriggerable. A configuration byte carries the floor code, the noise slope code, the enable bit and the over-deviation code. A separate 2-bit select picks the hold time.

Top module: `impulse_blanker`

## Requirements
- R1: While rst_ni is low, aud_o is 0, hold_active_o is 0 and the peak estimate is 0. All of these hold regardless of the inputs.
- R2: The base threshold is 65 - 5*code, where code is trig_cfg_i[2:0]. Code 0 gives 65 and code 7 gives 30. A trigger requires rect_i to be strictly greater than the effective peak plus the full threshold.
- R3: When the effective peak exceeds 90, the threshold gains an extra term ((peak_eff - 90) * (4 - s)) >> 1, where s is trig_cfg_i[4:3]. Code 0 is therefore the steepest slope. At or below 90, only the base threshold applies.
- R4: On the clock edge that registers a trigger, aud_o keeps the sample registered on the edge before. From the next output cycle, hold_active_o is high for N cycles, and aud_o does not change while hold_active_o is high.
- R5: A trigger that arrives during an active hold reloads the full hold length, counted from that trigger.
- R6: N is the hold time multiplied by the sample rate (parameter FS_KHZ, default 200 kHz) and rounded to the nearest count. hold_sel_i codes 0, 1, 2 and 3 select 38, 25.5, 32 and 22 us. The defaults give 8, 5, 6 and 4 cycles.
- R7: When trig_cfg_i[5] is 0, the block never triggers. Any pending hold is cleared on the next edge, and aud_o equals aud_i from the previous cycle.
- R8: The effective peak is the peak estimate plus an offset set by trig_cfg_i[7:6]. Code 0 adds 48, code 1 adds 32, code 2 adds 16 and code 3 adds nothing.
- R9: On every edge, the peak estimate moves by (rect_i - peak) arithmetically shifted right by 4. This update happens whether the blanker is enabled or not. With a steady input of 200, the estimate settles at 185.
- R10: When the blanker is enabled and neither triggering nor holding, aud_o follows aud_i with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, one sample per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rect_i | input | 12 | Rectified high-band magnitude, unsigned |
| aud_i | input | 16 | Audio sample matching rect_i |
| trig_cfg_i | input | 8 | [2:0] base threshold code, [4:3] noise slope, [5] enable, [7:6] over-deviation code |
| hold_sel_i | input | 2 | Hold time select |
| aud_o | output | 16 | Audio out, frozen during a hold |
| hold_active_o | output | 1 | High for each cycle of a hold |

## Verification
A vector sequence walks the block through three cases. The first is a quiet stream whose rect_i sits exactly on the trigger level and then one unit above it, which checks that the comparison is strict while the peak drifts. The second is an isolated spike, which checks the hold length and the frozen output value. The third is a second spike inside the hold, which can only pass if the interval restarts. Single-sample probes after reset then step the base, slope and over-deviation codes on both sides of each computed limit. Those limits include a peak primed to 185 while the blanker is disabled, which separates the noise term from the floor. Hold-length counting per select code and disable during an active hold complete the set.

// File: rtl/blanker_pkg.sv
package blanker_pkg;

  typedef struct packed {
    logic [1:0] ovd;
    logic       en;
    logic [1:0] slope;
    logic [2:0] low;
  } trig_cfg_t;

  // hold time in tenths of a microsecond per select code
  function automatic int unsigned hold_t10(input int unsigned code);
    case (code)
      0:       return 380;
      1:       return 255;
      2:       return 320;
      default: return 220;
    endcase
  endfunction

  // rounded sample count, never zero
  function automatic int unsigned hold_cycles(input int unsigned t10, input int unsigned fs_khz);
    int unsigned n;
    n = (t10 * fs_khz + 5000) / 10000;
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/blanker_peak.sv
module blanker_peak #(
  parameter int MAG_W = 12,
  parameter int SHIFT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MAG_W-1:0] rect_i,
  output logic [MAG_W-1:0] peak_o
);

  logic [MAG_W-1:0]        peak_q;
  logic signed [MAG_W:0]   diff;
  logic signed [MAG_W:0]   step;

  always_comb begin
    diff = $signed({1'b0, rect_i}) - $signed({1'b0, peak_q});
    step = diff >>> SHIFT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) peak_q <= '0;
    else         peak_q <= MAG_W'($unsigned($signed({1'b0, peak_q}) + step));
  end

  assign peak_o = peak_q;

endmodule

// File: rtl/blanker_thresh.sv
module blanker_thresh #(
  parameter int MAG_W    = 12,
  parameter int LIM_W    = MAG_W + 4,
  parameter int LOW_MAX  = 65,
  parameter int LOW_STEP = 5,
  parameter int FLOOR    = 90,
  parameter int OVD_STEP = 16
) (
  input  logic [MAG_W-1:0] peak_i,
  input  logic [2:0]       low_i,
  input  logic [1:0]       slope_i,
  input  logic [1:0]       ovd_i,
  output logic [LIM_W-1:0] limit_o
);

  logic [LIM_W-1:0] ovd_off;
  logic [LIM_W-1:0] low_thr;
  logic [LIM_W-1:0] peak_eff;
  logic [LIM_W-1:0] excess;
  logic [LIM_W-1:0] noise;
  logic [2:0]       gain;

  always_comb begin
    case (ovd_i)
      2'd0:    ovd_off = LIM_W'(3 * OVD_STEP);
      2'd1:    ovd_off = LIM_W'(2 * OVD_STEP);
      2'd2:    ovd_off = LIM_W'(OVD_STEP);
      default: ovd_off = '0;
    endcase
    low_thr  = LIM_W'(LOW_MAX) - LIM_W'(LOW_STEP) * LIM_W'(low_i);
    peak_eff = LIM_W'(peak_i) + ovd_off;
    excess   = (peak_eff > LIM_W'(FLOOR)) ? peak_eff - LIM_W'(FLOOR) : '0;
    // slope code 0 is steepest: gain 4..1, halved
    gain     = 3'd4 - {1'b0, slope_i};
    noise    = (excess * LIM_W'(gain)) >> 1;
    limit_o  = peak_eff + low_thr + noise;
  end

endmodule

// File: rtl/blanker_hold.sv
module blanker_hold
  import blanker_pkg::*;
#(
  parameter int AUD_W  = 16,
  parameter int FS_KHZ = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             en_i,
  input  logic [1:0]       sel_i,
  input  logic [AUD_W-1:0] aud_i,
  output logic [AUD_W-1:0] aud_o,
  output logic             hold_o
);

  localparam int unsigned HOLD_MAX = hold_cycles(hold_t10(0), FS_KHZ);
  localparam int          CNT_W    = $clog2(HOLD_MAX + 1);

  logic [CNT_W-1:0] len_tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_len
    assign len_tab[g] = CNT_W'(hold_cycles(hold_t10(g), FS_KHZ));
  end

  logic [CNT_W-1:0] cnt_q;
  logic [AUD_W-1:0] aud_q;
  logic             freeze;

  // hold the register on the trigger edge and on all but the last hold edge
  assign freeze = en_i && (trig_i || (cnt_q > CNT_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      aud_q <= '0;
    end else begin
      if (!en_i)             cnt_q <= '0;
      else if (trig_i)       cnt_q <= len_tab[sel_i];
      else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
      if (!freeze)           aud_q <= aud_i;
    end
  end

  assign aud_o  = aud_q;
  assign hold_o = (cnt_q != '0);

endmodule

// File: rtl/impulse_blanker.sv
module impulse_blanker
  import blanker_pkg::*;
#(
  parameter int MAG_W      = 12,
  parameter int AUD_W      = 16,
  parameter int PEAK_SHIFT = 4,
  parameter int FS_KHZ     = 200,
  parameter int LOW_MAX    = 65,
  parameter int LOW_STEP   = 5,
  parameter int FLOOR      = 90,
  parameter int OVD_STEP   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MAG_W-1:0] rect_i,
  input  logic [AUD_W-1:0] aud_i,
  input  logic [7:0]       trig_cfg_i,
  input  logic [1:0]       hold_sel_i,
  output logic [AUD_W-1:0] aud_o,
  output logic             hold_active_o
);

  localparam int LIM_W = MAG_W + 4;

  trig_cfg_t        cfg;
  logic [MAG_W-1:0] peak_q;
  logic [LIM_W-1:0] limit;
  logic             trig;

  assign cfg = trig_cfg_t'(trig_cfg_i);

  blanker_peak #(
    .MAG_W (MAG_W),
    .SHIFT (PEAK_SHIFT)
  ) i_peak (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rect_i (rect_i),
    .peak_o (peak_q)
  );

  blanker_thresh #(
    .MAG_W    (MAG_W),
    .LIM_W    (LIM_W),
    .LOW_MAX  (LOW_MAX),
    .LOW_STEP (LOW_STEP),
    .FLOOR    (FLOOR),
    .OVD_STEP (OVD_STEP)
  ) i_thresh (
    .peak_i  (peak_q),
    .low_i   (cfg.low),
    .slope_i (cfg.slope),
    .ovd_i   (cfg.ovd),
    .limit_o (limit)
  );

  assign trig = cfg.en && (LIM_W'(rect_i) > limit);

  blanker_hold #(
    .AUD_W  (AUD_W),
    .FS_KHZ (FS_KHZ)
  ) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig),
    .en_i   (cfg.en),
    .sel_i  (hold_sel_i),
    .aud_i  (aud_i),
    .aud_o  (aud_o),
    .hold_o (hold_active_o)
  );

endmodule

// File: rtl/blanker_checker.sv
module blanker_checker
  import blanker_pkg::*;
#(
  parameter int MAG_W   = 12,
  parameter int AUD_W   = 16,
  parameter int FS_KHZ  = 200,
  parameter int LOW_MIN = 30
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [MAG_W-1:0] rect_i,
  input logic [AUD_W-1:0] aud_i,
  input logic             en_i,
  input logic             trig_i,
  input logic [MAG_W-1:0] peak_i,
  input logic [AUD_W-1:0] aud_o,
  input logic             hold_o
);

  localparam int unsigned HOLD_MAX = hold_cycles(hold_t10(0), FS_KHZ);
  localparam int          RUN_W    = $clog2(HOLD_MAX + 2);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      run_q <= '0;
    else if (trig_i)                  run_q <= RUN_W'(1);
    else if (hold_o && run_q != '1)   run_q <= run_q + RUN_W'(1);
    else if (!hold_o)                 run_q <= '0;
  end

  p_trig_floor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |-> (rect_i > MAG_W'(LOW_MIN)));

  p_freeze_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> $stable(aud_o));

  p_trig_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> hold_o);

  p_hold_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> (run_q <= RUN_W'(HOLD_MAX)));

  p_off_no_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !hold_o);

  p_off_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (aud_o == $past(aud_i)));

  p_peak_up_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rect_i >= peak_i) |=> (peak_i >= $past(peak_i) && peak_i <= $past(rect_i)));

  p_peak_down_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rect_i <= peak_i) |=> (peak_i <= $past(peak_i) && peak_i >= $past(rect_i)));

endmodule

bind impulse_blanker blanker_checker #(
  .MAG_W   (MAG_W),
  .AUD_W   (AUD_W),
  .FS_KHZ  (FS_KHZ),
  .LOW_MIN (LOW_MAX - 7 * LOW_STEP)
) i_blanker_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rect_i (rect_i),
  .aud_i  (aud_i),
  .en_i   (trig_cfg_i[5]),
  .trig_i (trig),
  .peak_i (peak_q),
  .aud_o  (aud_o),
  .hold_o (hold_active_o)
);

// File: tb/test_impulse_blanker.sv
module test_impulse_blanker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] rect = '0;
  logic [15:0] aud = '0;
  logic [7:0]  cfg = '0;
  logic [1:0]  hsel = '0;
  logic [15:0] aud_out;
  logic        hold;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  impulse_blanker i_impulse_blanker (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .rect_i        (rect),
    .aud_i         (aud),
    .trig_cfg_i    (cfg),
    .hold_sel_i    (hsel),
    .aud_o         (aud_out),
    .hold_active_o (hold)
  );

  typedef struct packed {
    logic [11:0] rect;
    logic [15:0] aud;
    logic [15:0] exp_aud;
    logic        exp_hold;
  } vec_t;

  // base thr 65, slope 3, ovd off, hold 4 cycles; peak stays below 90
  localparam vec_t VECS [16] = '{
    '{12'd0,   16'd100, 16'd100, 1'b0},
    '{12'd65,  16'd101, 16'd101, 1'b0},
    '{12'd69,  16'd102, 16'd102, 1'b0},
    '{12'd74,  16'd103, 16'd102, 1'b1},
    '{12'd0,   16'd104, 16'd102, 1'b1},
    '{12'd0,   16'd105, 16'd102, 1'b1},
    '{12'd0,   16'd106, 16'd102, 1'b1},
    '{12'd0,   16'd107, 16'd107, 1'b0},
    '{12'd0,   16'd108, 16'd108, 1'b0},
    '{12'd200, 16'd109, 16'd108, 1'b1},
    '{12'd0,   16'd110, 16'd108, 1'b1},
    '{12'd200, 16'd111, 16'd108, 1'b1},
    '{12'd0,   16'd112, 16'd108, 1'b1},
    '{12'd0,   16'd113, 16'd108, 1'b1},
    '{12'd0,   16'd114, 16'd108, 1'b1},
    '{12'd0,   16'd115, 16'd115, 1'b0}
  };

  function automatic logic [7:0] mk_cfg(input logic [1:0] ovd, input logic en,
                                        input logic [1:0] slope, input logic [2:0] low);
    return {ovd, en, slope, low};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rect  = '0;
    aud   = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic [11:0] r, input logic [15:0] a);
    @(negedge clk);
    rect = r;
    aud  = a;
    @(posedge clk);
    #1;
  endtask

  task automatic thr_probe(input string req, input logic [7:0] c, input logic [11:0] r,
                           input int exp_hold);
    do_reset();
    cfg  = c;
    hsel = 2'd3;
    step(r, 16'd7);
    check(req, int'(hold), exp_hold);
  endtask

  task automatic slope_probe(input logic [1:0] s, input logic [11:0] r, input int exp_hold);
    do_reset();
    hsel = 2'd3;
    cfg  = mk_cfg(2'd3, 1'b0, s, 3'd0);
    repeat (150) step(12'd200, 16'd0);
    cfg = mk_cfg(2'd3, 1'b1, s, 3'd0);
    step(r, 16'd0);
    check("R3 R9 slope vs primed peak 185", int'(hold), exp_hold);
  endtask

  task automatic hold_len(input logic [1:0] s, input int exp_len);
    int n;
    do_reset();
    cfg  = mk_cfg(2'd3, 1'b1, 2'd3, 3'd0);
    hsel = s;
    step(12'd4000, 16'd1);
    n = 0;
    while (hold && n < 20) begin
      n++;
      step(12'd0, 16'd2);
    end
    check("R6 hold length", n, exp_len);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state with busy inputs
    rst_n = 1'b0;
    rect  = 12'd4000;
    aud   = 16'd1234;
    cfg   = mk_cfg(2'd3, 1'b1, 2'd3, 3'd0);
    repeat (3) @(posedge clk);
    #1;
    check("R1 aud_o in reset", int'(aud_out), 0);
    check("R1 hold in reset", int'(hold), 0);

    // R4 R5 R10 R2: vector walk
    do_reset();
    cfg  = mk_cfg(2'd3, 1'b1, 2'd3, 3'd0);
    hsel = 2'd3;
    foreach (VECS[i]) begin
      step(VECS[i].rect, VECS[i].aud);
      check($sformatf("R4 R5 R10 vec %0d aud", i), int'(aud_out), int'(VECS[i].exp_aud));
      check($sformatf("R2 R4 R5 vec %0d hold", i), int'(hold), int'(VECS[i].exp_hold));
    end

    // R2: base threshold codes, peak 0
    thr_probe("R2 code0 at limit",   mk_cfg(2'd3, 1'b1, 2'd3, 3'd0), 12'd65, 0);
    thr_probe("R2 code0 above",      mk_cfg(2'd3, 1'b1, 2'd3, 3'd0), 12'd66, 1);
    thr_probe("R2 code3 at limit",   mk_cfg(2'd3, 1'b1, 2'd3, 3'd3), 12'd50, 0);
    thr_probe("R2 code3 above",      mk_cfg(2'd3, 1'b1, 2'd3, 3'd3), 12'd51, 1);
    thr_probe("R2 code7 at limit",   mk_cfg(2'd3, 1'b1, 2'd3, 3'd7), 12'd30, 0);
    thr_probe("R2 code7 above",      mk_cfg(2'd3, 1'b1, 2'd3, 3'd7), 12'd31, 1);

    // R8: over-deviation offsets, peak 0 stays below 90 after offset
    thr_probe("R8 ovd0 at limit",    mk_cfg(2'd0, 1'b1, 2'd3, 3'd0), 12'd113, 0);
    thr_probe("R8 ovd0 above",       mk_cfg(2'd0, 1'b1, 2'd3, 3'd0), 12'd114, 1);
    thr_probe("R8 ovd2 at limit",    mk_cfg(2'd2, 1'b1, 2'd3, 3'd0), 12'd81, 0);
    thr_probe("R8 ovd2 above",       mk_cfg(2'd2, 1'b1, 2'd3, 3'd0), 12'd82, 1);

    // R3 R9: noise slope above the floor
    slope_probe(2'd0, 12'd440, 0);
    slope_probe(2'd0, 12'd441, 1);
    slope_probe(2'd1, 12'd392, 0);
    slope_probe(2'd1, 12'd393, 1);
    slope_probe(2'd3, 12'd297, 0);
    slope_probe(2'd3, 12'd298, 1);

    // R6: hold lengths per select code
    hold_len(2'd0, 8);
    hold_len(2'd1, 5);
    hold_len(2'd2, 6);
    hold_len(2'd3, 4);

    // R7: disabled blanker passes spikes and cancels a hold
    do_reset();
    hsel = 2'd0;
    cfg  = mk_cfg(2'd3, 1'b0, 2'd3, 3'd0);
    step(12'd4000, 16'd500);
    check("R7 disabled aud", int'(aud_out), 500);
    check("R7 disabled hold", int'(hold), 0);
    step(12'd4000, 16'd501);
    check("R7 disabled aud 2", int'(aud_out), 501);
    cfg = mk_cfg(2'd3, 1'b1, 2'd3, 3'd0);
    step(12'd4000, 16'd600);
    check("R4 hold on spike", int'(hold), 1);
    check("R4 held value", int'(aud_out), 501);
    cfg = mk_cfg(2'd3, 1'b0, 2'd3, 3'd0);
    step(12'd0, 16'd601);
    check("R7 hold cleared", int'(hold), 0);
    check("R7 pass after clear", int'(aud_out), 601);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule